// File: doc/BRIEF.md
# Ring Packet Transmitter With Return Confirmation

This block is one node's sending and forwarding stage on a register-insertion ring. A local source offers write updates (word address, 32-bit data word, interrupt flag). The block wraps each update into a fixed 82-bit packet that carries the node's own identifier and a parity bit, and shifts it onto the ring one bit per cycle. The ring carries the packet through every other node and back to the sender. The block removes its own packet when it comes back. A clean return confirms delivery. A return with bad parity, or no return before a programmable timeout, makes the block send the packet again and count the retry.

Packets that other nodes sent are passed on unchanged. Packets with good parity are also presented on a local write port, so that the node's local copy of the shared memory can be updated. A packet that arrives while the node is shifting out its own packet waits in a one-packet insertion buffer and goes out as soon as the shifter is free. All nodes have the same standing on the ring. The packet length never changes, so every transfer takes the same number of cycles. Interrupt messages are ordinary packets with the flag bit set.

Top module: `ringPacketTx`

## Requirements
- R1: A packet is 82 bits. Data sits in bits 31:0, the word address in bits 46:32, the source node ID in bits 54:47, the interrupt flag in bit 55 and the parity in bit 81. Bits 80:56 are always sent as zero.
- R2: The parity bit is chosen so that the XOR of all 82 bits of a packet is zero (even parity).
- R3: A packet goes out least significant bit first on ringOutBit. ringOutVld is high for exactly 82 consecutive cycles per packet, and received packets are framed the same way on ringInBit/ringInVld.
- R4: txReady is high only when no own packet is outstanding. An entry is accepted when txValid and txReady are both high, and txReady stays low until that packet has returned with good parity.
- R5: If the own packet has not returned when retTimeout cycles have passed since its first bit went out, it is sent again. The first bit of the resend appears exactly retTimeout+2 cycles after the first bit of the previous attempt, and retryCount goes up by one.
- R6: A received packet whose source ID equals localId is never forwarded. If its parity is good, the outstanding entry is complete and retryCount does not change. If its parity is bad, the packet is sent again and retryCount goes up by one.
- R7: A received packet from another node with good parity is forwarded bit for bit unchanged. Its source, address, data and flag appear on the write port with wrValid high for one cycle, in the cycle after its last bit is sampled.
- R8: A received packet from another node with bad parity is still forwarded unchanged, but wrValid does not pulse for it.
- R9: A foreign packet that completes while the shifter is busy is held in a one-packet buffer and forwarded after the current packet. A held packet is sent before a pending own packet.
- R10: The interrupt flag of an accepted entry is carried in bit 55 of the packet. The flag of a received foreign packet is reported on wrIrq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| localId | input | 8 | This node's identifier |
| retTimeout | input | 16 | Return timeout in cycles |
| txValid | input | 1 | Transmit entry offered |
| txReady | output | 1 | Entry can be accepted |
| txAddr | input | 15 | Word address of the entry |
| txData | input | 32 | Data word of the entry |
| txIrq | input | 1 | Entry is an interrupt message |
| ringInBit | input | 1 | Serial data from upstream |
| ringInVld | input | 1 | Upstream bit is valid |
| ringOutBit | output | 1 | Serial data to downstream |
| ringOutVld | output | 1 | Downstream bit is valid |
| wrValid | output | 1 | Foreign update delivered |
| wrSrc | output | 8 | Source node of the update |
| wrAddr | output | 15 | Word address of the update |
| wrData | output | 32 | Data word of the update |
| wrIrq | output | 1 | Update carries the interrupt flag |
| retryCount | output | 16 | Number of resends so far |

## Verification
A received packet shows up on the write port one cycle after its last bit is sampled. A foreign packet starts back out two cycles after its last bit if the shifter is idle, or one cycle after the current packet ends if it is not. A resend starts retTimeout+2 cycles after the previous attempt. The bench records the cycle at which each outgoing packet starts and checks the timeout gap against that exact figure. Outgoing packets and write-port updates are compared, in order, against queues of expected items as each one finishes. Checks of txReady and retryCount are made a few cycles after an echo has been fully driven, once the block has settled.

// File: rtl/ringTxPkg.sv
package ringTxPkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 15;
  localparam int ID_W   = 8;
  localparam int PKT_W  = 82;
  localparam int RSV_W  = PKT_W - DATA_W - ADDR_W - ID_W - 2;

  typedef struct packed {
    logic              par;
    logic [RSV_W-1:0]  rsv;
    logic              irq;
    logic [ID_W-1:0]   src;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } pkt_t;

  typedef struct packed {
    logic latchEntry;
    logic loadOwn;
    logic loadFwd;
    logic fwdCapture;
    logic startTimer;
    logic incRetry;
  } ctl_t;

  typedef enum logic [1:0] {S_IDLE, S_PEND, S_WAIT} st_t;

  function automatic pkt_t buildPkt(input logic [ID_W-1:0] src, input logic [ADDR_W-1:0] addr,
                                    input logic [DATA_W-1:0] data, input logic irq);
    pkt_t p;
    p      = '0;
    p.src  = src;
    p.addr = addr;
    p.data = data;
    p.irq  = irq;
    p.par  = ^p;
    return p;
  endfunction
endpackage

// File: rtl/ringTxDatapath.sv
module ringTxDatapath
  import ringTxPkg::*;
#(
  parameter int TMR_W = 16,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [ID_W-1:0]   localId,
  input  logic [TMR_W-1:0]  retTimeout,
  input  logic [ADDR_W-1:0] txAddr,
  input  logic [DATA_W-1:0] txData,
  input  logic              txIrq,
  input  logic              ringInBit,
  input  logic              ringInVld,
  output logic              ringOutBit,
  output logic              ringOutVld,
  output logic              wrValid,
  output logic [ID_W-1:0]   wrSrc,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrIrq,
  output logic [CNT_W-1:0]  retryCount,
  output logic              rxDone,
  output logic              rxOwn,
  output logic              rxParOk,
  output logic              bufValid,
  output logic              shBusy,
  output logic              timeout
);
  localparam int BIT_W = $clog2(PKT_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(PKT_W - 1);

  logic [BIT_W-1:0] rxCnt, shCnt;
  logic [PKT_W-1:0] rxSh, shReg;
  pkt_t             rxPkt, bufPkt, entryPkt, shSrc;
  logic [TMR_W-1:0] tmr;

  // receive deserializer, LSB first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxCnt  <= '0;
      rxSh   <= '0;
      rxPkt  <= '0;
      rxDone <= 1'b0;
    end else begin
      rxDone <= 1'b0;
      if (ringInVld) begin
        rxSh <= {ringInBit, rxSh[PKT_W-1:1]};
        if (rxCnt == LAST_BIT) begin
          rxCnt  <= '0;
          rxDone <= 1'b1;
          rxPkt  <= pkt_t'({ringInBit, rxSh[PKT_W-1:1]});
        end else begin
          rxCnt <= rxCnt + 1'b1;
        end
      end else begin
        rxCnt <= '0;
      end
    end
  end

  assign rxOwn   = (rxPkt.src == localId);
  assign rxParOk = ~^rxPkt;

  // local write port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrValid <= 1'b0;
      wrSrc   <= '0;
      wrAddr  <= '0;
      wrData  <= '0;
      wrIrq   <= 1'b0;
    end else begin
      wrValid <= rxDone && !rxOwn && rxParOk;
      if (rxDone) begin
        wrSrc  <= rxPkt.src;
        wrAddr <= rxPkt.addr;
        wrData <= rxPkt.data;
        wrIrq  <= rxPkt.irq;
      end
    end
  end

  // one-packet insertion buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufValid <= 1'b0;
      bufPkt   <= '0;
    end else if (ctl.fwdCapture) begin
      bufValid <= 1'b1;
      bufPkt   <= rxPkt;
    end else if (ctl.loadFwd) begin
      bufValid <= 1'b0;
    end
  end

  // own entry register
  always_ff @(posedge clk) begin
    if (!rstN) entryPkt <= '0;
    else if (ctl.latchEntry) entryPkt <= buildPkt(localId, txAddr, txData, txIrq);
  end

  // transmit shifter
  assign shSrc = ctl.loadFwd ? bufPkt : entryPkt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      shCnt  <= '0;
      shBusy <= 1'b0;
    end else if (shBusy) begin
      shReg <= {1'b0, shReg[PKT_W-1:1]};
      if (shCnt == LAST_BIT) begin
        shBusy <= 1'b0;
        shCnt  <= '0;
      end else begin
        shCnt <= shCnt + 1'b1;
      end
    end else if (ctl.loadFwd || ctl.loadOwn) begin
      shReg  <= shSrc;
      shCnt  <= '0;
      shBusy <= 1'b1;
    end
  end

  assign ringOutBit = shReg[0];
  assign ringOutVld = shBusy;

  // return timer, saturating
  always_ff @(posedge clk) begin
    if (!rstN) tmr <= '0;
    else if (ctl.startTimer) tmr <= '0;
    else if (tmr != {TMR_W{1'b1}}) tmr <= tmr + 1'b1;
  end

  assign timeout = (tmr >= retTimeout);

  always_ff @(posedge clk) begin
    if (!rstN) retryCount <= '0;
    else if (ctl.incRetry) retryCount <= retryCount + 1'b1;
  end
endmodule

// File: rtl/ringTxControl.sv
module ringTxControl
  import ringTxPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic txValid,
  input  logic rxDone,
  input  logic rxOwn,
  input  logic rxParOk,
  input  logic bufValid,
  input  logic shBusy,
  input  logic timeout,
  output logic txReady,
  output ctl_t ctl
);
  st_t st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= S_IDLE;
    else st <= nxt;
  end

  always_comb begin
    ctl            = '0;
    nxt            = st;
    ctl.fwdCapture = rxDone && !rxOwn;
    ctl.loadFwd    = !shBusy && bufValid;
    case (st)
      S_IDLE: begin
        if (txValid) begin
          ctl.latchEntry = 1'b1;
          nxt            = S_PEND;
        end
      end
      S_PEND: begin
        if (!shBusy && !bufValid) begin
          ctl.loadOwn    = 1'b1;
          ctl.startTimer = 1'b1;
          nxt            = S_WAIT;
        end
      end
      S_WAIT: begin
        if (rxDone && rxOwn) begin
          if (rxParOk) begin
            nxt = S_IDLE;
          end else begin
            ctl.incRetry = 1'b1;
            nxt          = S_PEND;
          end
        end else if (timeout) begin
          ctl.incRetry = 1'b1;
          nxt          = S_PEND;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign txReady = (st == S_IDLE);
endmodule

// File: rtl/ringPacketTx.sv
module ringPacketTx
  import ringTxPkg::*;
#(
  parameter int TMR_W = 16,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ID_W-1:0]   localId,
  input  logic [TMR_W-1:0]  retTimeout,
  input  logic              txValid,
  output logic              txReady,
  input  logic [ADDR_W-1:0] txAddr,
  input  logic [DATA_W-1:0] txData,
  input  logic              txIrq,
  input  logic              ringInBit,
  input  logic              ringInVld,
  output logic              ringOutBit,
  output logic              ringOutVld,
  output logic              wrValid,
  output logic [ID_W-1:0]   wrSrc,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrIrq,
  output logic [CNT_W-1:0]  retryCount
);
  ctl_t ctl;
  logic rxDone, rxOwn, rxParOk, bufValid, shBusy, timeout;

  ringTxControl u_ctl (
    .clk(clk), .rstN(rstN), .txValid(txValid), .rxDone(rxDone), .rxOwn(rxOwn),
    .rxParOk(rxParOk), .bufValid(bufValid), .shBusy(shBusy), .timeout(timeout),
    .txReady(txReady), .ctl(ctl)
  );

  ringTxDatapath #(.TMR_W(TMR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .localId(localId), .retTimeout(retTimeout),
    .txAddr(txAddr), .txData(txData), .txIrq(txIrq),
    .ringInBit(ringInBit), .ringInVld(ringInVld),
    .ringOutBit(ringOutBit), .ringOutVld(ringOutVld),
    .wrValid(wrValid), .wrSrc(wrSrc), .wrAddr(wrAddr), .wrData(wrData), .wrIrq(wrIrq),
    .retryCount(retryCount), .rxDone(rxDone), .rxOwn(rxOwn), .rxParOk(rxParOk),
    .bufValid(bufValid), .shBusy(shBusy), .timeout(timeout)
  );
endmodule

// File: rtl/ringTxChecker.sv
module ringTxChecker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             txValid,
  input logic             txReady,
  input logic             ringOutVld,
  input logic             rxDone,
  input logic             rxOwn,
  input logic             rxParOk,
  input logic             bufValid,
  input logic             wrValid,
  input logic [CNT_W-1:0] retryCount
);
  logic [7:0] lenCnt;

  always_ff @(posedge clk) begin
    if (!rstN) lenCnt <= '0;
    else if (ringOutVld) lenCnt <= lenCnt + 1'b1;
    else lenCnt <= '0;
  end

  a_r3_frame_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ringOutVld) |-> lenCnt == 8'd82);

  a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

  a_r5_retry_step: assert property (@(posedge clk) disable iff (!rstN)
    (retryCount == $past(retryCount)) || (retryCount == $past(retryCount) + 1'b1));

  a_r7_deliver_next: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && !rxOwn && rxParOk) |=> wrValid);

  a_r8_no_bad_write: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && !rxParOk) |=> !wrValid);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    !(rxDone && !rxOwn && bufValid && ringOutVld));
endmodule

bind ringPacketTx ringTxChecker #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_ringPacketTx.sv
module test_ringPacketTx;
  localparam int TMO = 300;
  localparam logic [7:0] MY_ID = 8'h5A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] localId = MY_ID;
  logic [15:0] retTimeout = 16'(TMO);
  logic txValid = 1'b0, txIrq = 1'b0;
  logic [14:0] txAddr = '0;
  logic [31:0] txData = '0;
  logic ringInBit = 1'b0, ringInVld = 1'b0;
  logic txReady, ringOutBit, ringOutVld, wrValid, wrIrq;
  logic [7:0] wrSrc;
  logic [14:0] wrAddr;
  logic [31:0] wrData;
  logic [15:0] retryCount;

  ringPacketTx i_ringPacketTx (.*);

  always #4 clk = ~clk;

  int nChk = 0, nBad = 0, cyc = 0, pktsSeen = 0, wrSeen = 0;
  int lastStart = 0, prevStart = 0, bitIdx = 0;
  logic [81:0] cap;
  logic [81:0] expQ[$];
  logic [55:0] expWrQ[$];
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [81:0] mk(input logic [7:0] s, input logic [14:0] a,
                                     input logic [31:0] d, input logic irq);
    logic [81:0] p;
    p = '0;
    p[31:0] = d; p[46:32] = a; p[54:47] = s; p[55] = irq;
    p[81] = ^p;
    return p;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [81:0] act, input logic [81:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // ring output monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && ringOutVld) begin
      if (bitIdx == 0) begin prevStart = lastStart; lastStart = cyc; end
      cap[bitIdx] = ringOutBit;
      bitIdx++;
      if (bitIdx == 82) begin
        bitIdx = 0;
        pktsSeen++;
        if (expQ.size() == 0) chk(0, "R6 unexpected ring packet", cap, '0);
        else begin
          logic [81:0] e;
          e = expQ.pop_front();
          chk(cap == e, "R1 R2 R3 ring packet", cap, e);
        end
      end
    end
  end

  // write port monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && wrValid) begin
      wrSeen++;
      if (expWrQ.size() == 0) chk(0, "R8 unexpected write", {26'd0, wrSrc, wrIrq, wrAddr, wrData}, '0);
      else begin
        logic [55:0] e;
        e = expWrQ.pop_front();
        chk({wrSrc, wrIrq, wrAddr, wrData} == e, "R7 R10 write port",
            {26'd0, wrSrc, wrIrq, wrAddr, wrData}, {26'd0, e});
      end
    end
  end

  task automatic sendRing(input logic [81:0] p);
    for (int i = 0; i < 82; i++) begin
      @(negedge clk);
      ringInBit = p[i];
      ringInVld = 1'b1;
    end
    @(negedge clk);
    ringInVld = 1'b0;
  endtask

  task automatic pushTx(input logic [14:0] a, input logic [31:0] d, input logic irq);
    @(negedge clk);
    txAddr = a; txData = d; txIrq = irq; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    chk(txReady == 1'b0, "R4 busy after accept", 82'(txReady), 82'd0);
  endtask

  task automatic waitPkts(input int n);
    while (pktsSeen < n) @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChk++; nBad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [81:0] pA, pB, pC, pD, pF, pG, pH;
    int w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(txReady == 1'b1, "R4 reset ready", 82'(txReady), 82'd1);
    chk(ringOutVld == 1'b0, "R3 reset idle", 82'(ringOutVld), 82'd0);
    chk(retryCount == 16'd0, "R5 reset retry", 82'(retryCount), 82'd0);
    chk(wrValid == 1'b0, "R7 reset write", 82'(wrValid), 82'd0);

    // R1 R2 R10: own entry with interrupt flag, clean return
    pA = mk(MY_ID, 15'h1234, 32'hDEADBEEF, 1'b1);
    expQ.push_back(pA);
    pushTx(15'h1234, 32'hDEADBEEF, 1'b1);
    waitPkts(1);
    chk(pA[55] == 1'b1 && ^pA == 1'b0, "R10 R2 flag and parity", pA, pA);
    chk(txReady == 1'b0, "R4 waiting for return", 82'(txReady), 82'd0);
    sendRing(pA);
    settle();
    chk(txReady == 1'b1, "R4 ready after clean return", 82'(txReady), 82'd1);
    chk(retryCount == 16'd0, "R6 no retry on clean return", 82'(retryCount), 82'd0);
    chk(pktsSeen == 1, "R6 own packet not forwarded", 82'(pktsSeen), 82'd1);

    // R5: timeout resend
    pB = mk(MY_ID, 15'h0042, 32'h01020304, 1'b0);
    expQ.push_back(pB);
    expQ.push_back(pB);
    pushTx(15'h0042, 32'h01020304, 1'b0);
    waitPkts(3);
    chk(lastStart - prevStart == TMO + 2, "R5 resend gap", 82'(lastStart - prevStart), 82'(TMO + 2));
    chk(retryCount == 16'd1, "R5 retry after timeout", 82'(retryCount), 82'd1);
    sendRing(pB);
    settle();
    chk(txReady == 1'b1, "R4 ready after resend returns", 82'(txReady), 82'd1);

    // R6: bad-parity return
    pC = mk(MY_ID, 15'h7FFF, 32'hA5A5A5A5, 1'b0);
    expQ.push_back(pC);
    expQ.push_back(pC);
    pushTx(15'h7FFF, 32'hA5A5A5A5, 1'b0);
    waitPkts(4);
    sendRing(pC ^ (82'd1 << 5));
    waitPkts(5);
    chk(retryCount == 16'd2, "R6 retry after parity error", 82'(retryCount), 82'd2);
    sendRing(pC);
    settle();
    chk(txReady == 1'b1, "R6 ready after clean return", 82'(txReady), 82'd1);
    chk(pktsSeen == 5, "R6 returns stripped", 82'(pktsSeen), 82'd5);

    // R7 R10: foreign good packet with flag
    pF = mk(8'h21, 15'h0ABC, 32'hCAFEF00D, 1'b1);
    expQ.push_back(pF);
    expWrQ.push_back({8'h21, 1'b1, 15'h0ABC, 32'hCAFEF00D});
    w = wrSeen;
    sendRing(pF);
    waitPkts(6);
    chk(wrSeen == w + 1, "R7 write delivered", 82'(wrSeen), 82'(w + 1));

    // R8: foreign bad parity packet
    pG = mk(8'h33, 15'h0011, 32'h00000022, 1'b0) ^ (82'd1 << 40);
    expQ.push_back(pG);
    w = wrSeen;
    sendRing(pG);
    waitPkts(7);
    settle();
    chk(wrSeen == w, "R8 no write for bad parity", 82'(wrSeen), 82'(w));

    // R9: foreign arrival during own transmission is held and sent afterward
    pD = mk(MY_ID, 15'h0100, 32'h11223344, 1'b0);
    pH = mk(8'h44, 15'h0200, 32'h55667788, 1'b0);
    expQ.push_back(pD);
    expQ.push_back(pH);
    expWrQ.push_back({8'h44, 1'b0, 15'h0200, 32'h55667788});
    fork
      sendRing(pH);
      begin
        repeat (5) @(negedge clk);
        pushTx(15'h0100, 32'h11223344, 1'b0);
      end
    join
    waitPkts(9);
    chk(lastStart - prevStart == 83, "R9 held packet follows own", 82'(lastStart - prevStart), 82'd83);
    sendRing(pD);
    settle();
    chk(txReady == 1'b1, "R9 own entry completed", 82'(txReady), 82'd1);
    chk(expQ.size() == 0, "R3 all packets seen", 82'(expQ.size()), 82'd0);
    chk(expWrQ.size() == 0, "R7 all writes seen", 82'(expWrQ.size()), 82'd0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule